// File: doc/BRIEF.md
# Timestamped Capture Cluster Decoder

This block turns the compressed contents of a logic-capture memory into a flat stream of 16-bit sample words. The memory is read out as 512 sixteen-bit words per chunk. Each word carries its first memory byte in bits 7:0 and its second in bits 15:8. A chunk is made of 64 clusters of eight words. The first word of a cluster is a timestamp, and the next seven words are event words. Depending on the rate mode, one event word holds one, two or four time-ordered samples, with the channel bits interleaved. The block takes these samples apart and writes them out with the channel number as the bit index.

Timestamps count event slots. When the timestamp step between two consecutive clusters is more than the cluster's own length, the idle time was not stored. The block rebuilds it by repeating the last emitted sample. The capture length and an optional trigger location are given as counter positions of 512 units per chunk. The final chunk may be only partly valid, so decoding ends at the first cluster in it whose timestamp lies beyond the stop point. The configuration inputs are sampled while reset is held and must stay stable for the whole run. The upstream source must hold its word and valid while it waits for ready.

Top module: `ts_cluster_decoder`

## Requirements
- R1: While reset is low and in the cycle after it, `smp_valid` is 0. `finished` is 1 exactly when `stop_pos` is 0. Otherwise `word_ready` is 1, waiting for the first timestamp.
- R2: The first word of each cluster is consumed as a timestamp without producing a sample. The seven words after it are event words.
- R3: Mode select 0 gives one sample per event (16 channels), 1 gives two (8 channels), and 2 or 3 gives four (4 channels). Sample k of an event takes channel l from event bit l*spe+k and places it at output bit l. Output bits at or above the channel count are 0. Samples leave in order k = 0 first.
- R4: Before the events of a cluster, the block emits (timestamp step × spe − 7 × spe) fill samples when that value is positive, and none otherwise. The step is taken modulo 2^16.
- R5: Every fill sample equals the last sample emitted before it. Before the first event sample of a run, the last sample is 0.
- R6: The first cluster of a run is treated as if the previous timestamp were its own value minus one, so it gets no fill.
- R7: The block processes ceil(`stop_pos`/512) chunks and then raises `finished`. While `finished` is 1, `smp_valid` and `word_ready` are 0, and `finished` stays 1 until reset.
- R8: At the first cluster of the final chunk, a limit is fixed at (`stop_pos` mod 512) plus the previous timestamp, where R6 applies if that cluster is the first of the run. Decoding finishes at the first cluster of that chunk whose timestamp exceeds the limit. That cluster produces no samples.
- R9: When `trig_en` is 1, `smp_trig` marks the first event sample of cluster (`trig_pos` mod 512)/7 in chunk `trig_pos`/512. It marks no other sample, and it is only ever high together with `smp_valid`.
- R10: While `smp_valid` is high and `smp_ready` is low, the sample, its marker and its valid hold steady into the next cycle.
- R11: An event word is accepted only together with the handshake of its last sample. Fill samples are emitted without accepting input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, restarts a run |
| rate_sel | input | 2 | Samples-per-event mode (0:1, 1:2, 2/3:4) |
| stop_pos | input | POS_W | Capture stop counter position |
| trig_en | input | 1 | Enable the in-stream trigger marker |
| trig_pos | input | POS_W | Trigger counter position |
| word_in | input | SMP_W | Memory word, first byte in the low half |
| word_valid | input | 1 | word_in is valid |
| word_ready | output | 1 | word_in is consumed at this edge |
| smp_out | output | SMP_W | Decoded sample, channel l at bit l |
| smp_trig | output | 1 | Marks the trigger sample |
| smp_valid | output | 1 | smp_out is valid |
| smp_ready | input | 1 | Downstream accepts the sample |
| finished | output | 1 | Run complete |

## Verification
The bench aims at the first cluster of a run: a design that skips the minus-one seeding would emit a burst of stale fill or leave out the 0 start value. It also covers a final chunk whose stop offset is zero, where a wrong limit would decode a whole extra chunk or a stray cluster, and a final chunk that is also the first chunk. The two- and four-sample modes catch a swapped sub-sample or channel index as scrambled bits. Periodic downstream stalls catch any counter that moves while a sample is held, which would show up as a dropped or doubled sample. The trigger checks compare the marker position against the expected sample index, so a marker placed one cluster off, or placed in a chunk that is never reached, is reported.

// File: rtl/tcd_pkg.sv
// Shared definitions for the capture cluster decoder.
// Assumes rate select codes 0/1/2 map to 1/2/4 samples per event, 3 aliases 2.
package tcd_pkg;

    typedef enum logic [1:0] {
        ST_STAMP = 2'd0,
        ST_FILL  = 2'd1,
        ST_EVENT = 2'd2,
        ST_DONE  = 2'd3
    } tcd_state_t;

    // log2 of samples per event for a rate select code
    function automatic logic [1:0] spe_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    spe_shift = 2'd0;
            2'd1:    spe_shift = 2'd1;
            default: spe_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/tcd_unpack.sv
// De-interleaves one event word into the sub-sample selected by sub_idx.
// Assumes SMP_W is divisible by 4; unused high channels are driven to 0.
module tcd_unpack #(
    parameter int SMP_W = 16
) (
    input  logic [SMP_W-1:0] ev_word,
    input  logic [1:0]       shift,
    input  logic [1:0]       sub_idx,
    output logic [SMP_W-1:0] smp
);
    localparam int HALF = SMP_W / 2;
    localparam int QUAR = SMP_W / 4;

    // pick channel bits for the requested sub-sample
    always_comb begin
        smp = '0;
        case (shift)
            2'd0: smp = ev_word;
            2'd1: for (int l = 0; l < HALF; l++) smp[l] = ev_word[2*l + int'(sub_idx[0])];
            default: for (int l = 0; l < QUAR; l++) smp[l] = ev_word[4*l + int'(sub_idx)];
        endcase
    end
endmodule

// File: rtl/tcd_gap.sv
// Computes the fill count implied by a timestamp step.
// Assumes the step is measured modulo 2^TS_W; a first cluster counts as step 1.
module tcd_gap #(
    parameter int TS_W   = 16,
    parameter int EVENTS = 7,
    parameter int CNT_W  = TS_W + 3
) (
    input  logic [TS_W-1:0]  stamp,
    input  logic [TS_W-1:0]  prev_stamp,
    input  logic             first,
    input  logic [1:0]       shift,
    output logic [CNT_W-1:0] fill_cnt,
    output logic             fill_any
);
    logic [TS_W-1:0]  step;
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] own;

    // scale the step and the cluster length by samples per event
    always_comb begin
        step     = first ? TS_W'(1) : (stamp - prev_stamp);
        span     = CNT_W'(step) << shift;
        own      = CNT_W'(EVENTS) << shift;
        fill_any = span > own;
        fill_cnt = span - own;
    end
endmodule

// File: rtl/ts_cluster_decoder.sv
// Decodes timestamped capture clusters into a flat sample stream.
// Assumes config inputs are stable from reset to finish and that the source
// holds word_in/word_valid until word_ready.
module ts_cluster_decoder #(
    parameter int SMP_W     = 16,
    parameter int POS_W     = 24,
    parameter int EVENTS    = 7,
    parameter int CLUSTERS  = 64,
    parameter int CHUNK_POS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_sel,
    input  logic [POS_W-1:0] stop_pos,
    input  logic             trig_en,
    input  logic [POS_W-1:0] trig_pos,
    input  logic [SMP_W-1:0] word_in,
    input  logic             word_valid,
    output logic             word_ready,
    output logic [SMP_W-1:0] smp_out,
    output logic             smp_trig,
    output logic             smp_valid,
    input  logic             smp_ready,
    output logic             finished
);
    import tcd_pkg::*;

    localparam int OFF_W = $clog2(CHUNK_POS);
    localparam int CH_W  = POS_W - OFF_W + 1;
    localparam int CLU_W = $clog2(CLUSTERS);
    localparam int EV_W  = $clog2(EVENTS);
    localparam int CNT_W = SMP_W + 3;
    localparam int LIM_W = SMP_W + 1;

    tcd_state_t       state;
    logic [CH_W-1:0]  chunk;
    logic [CLU_W-1:0] clu;
    logic [EV_W-1:0]  ev;
    logic [1:0]       sub;
    logic [SMP_W-1:0] prev_stamp, last_smp;
    logic             first, trig_pend;
    logic [CNT_W-1:0] fill_left;
    logic [LIM_W-1:0] limit;

    logic [POS_W:0]   pos_round;
    logic [CH_W-1:0]  n_chunks;
    logic [1:0]       shift, sub_max;
    logic             is_final, trig_here, over_limit, sub_last;
    logic [SMP_W-1:0] eff_prev, ev_smp;
    logic [LIM_W-1:0] lim_now;
    logic [CNT_W-1:0] fill_cnt;
    logic             fill_any, smp_fire;

    // derived run geometry and per-cluster decisions
    always_comb begin
        pos_round  = {1'b0, stop_pos} + (POS_W+1)'(CHUNK_POS - 1);
        n_chunks   = pos_round[POS_W:OFF_W];
        shift      = spe_shift(rate_sel);
        sub_max    = (2'd1 << shift) - 2'd1;
        sub_last   = (sub == sub_max);
        is_final   = (chunk == n_chunks - CH_W'(1));
        eff_prev   = first ? (word_in - SMP_W'(1)) : prev_stamp;
        lim_now    = (clu == '0) ? (LIM_W'(stop_pos[OFF_W-1:0]) + LIM_W'(eff_prev)) : limit;
        over_limit = is_final && ({1'b0, word_in} > lim_now);
        trig_here  = trig_en && (chunk == {1'b0, trig_pos[POS_W-1:OFF_W]})
                     && (OFF_W'(clu) == trig_pos[OFF_W-1:0] / OFF_W'(EVENTS));
    end

    tcd_gap #(.TS_W(SMP_W), .EVENTS(EVENTS), .CNT_W(CNT_W)) u_gap (
        .stamp(word_in), .prev_stamp(prev_stamp), .first(first), .shift(shift),
        .fill_cnt(fill_cnt), .fill_any(fill_any)
    );

    tcd_unpack #(.SMP_W(SMP_W)) u_unpack (
        .ev_word(word_in), .shift(shift), .sub_idx(sub), .smp(ev_smp)
    );

    // output and input handshake steering per state
    always_comb begin
        smp_valid  = 1'b0;
        smp_out    = last_smp;
        word_ready = 1'b0;
        case (state)
            ST_STAMP: word_ready = 1'b1;
            ST_FILL:  smp_valid  = 1'b1;
            ST_EVENT: begin
                smp_valid  = word_valid;
                smp_out    = ev_smp;
                word_ready = smp_ready && sub_last;
            end
            default: ;
        endcase
        smp_trig = trig_pend && (state == ST_EVENT) && word_valid;
        finished = (state == ST_DONE);
        smp_fire = smp_valid && smp_ready;
    end

    // sequencing of clusters, fill, events and chunks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= (n_chunks == '0) ? ST_DONE : ST_STAMP;
            chunk      <= '0;
            clu        <= '0;
            ev         <= '0;
            sub        <= '0;
            prev_stamp <= '0;
            last_smp   <= '0;
            first      <= 1'b1;
            trig_pend  <= 1'b0;
            fill_left  <= '0;
            limit      <= '0;
        end else begin
            case (state)
                ST_STAMP: if (word_valid) begin
                    if (over_limit) begin
                        state <= ST_DONE;
                    end else begin
                        prev_stamp <= word_in;
                        first      <= 1'b0;
                        if (clu == '0) limit <= lim_now;
                        trig_pend  <= trig_here;
                        fill_left  <= fill_cnt;
                        ev         <= '0;
                        sub        <= '0;
                        state      <= fill_any ? ST_FILL : ST_EVENT;
                    end
                end
                ST_FILL: if (smp_ready) begin
                    fill_left <= fill_left - CNT_W'(1);
                    if (fill_left == CNT_W'(1)) state <= ST_EVENT;
                end
                ST_EVENT: if (smp_fire) begin
                    last_smp  <= ev_smp;
                    trig_pend <= 1'b0;
                    if (!sub_last) begin
                        sub <= sub + 2'd1;
                    end else begin
                        sub <= '0;
                        if (ev != EV_W'(EVENTS - 1)) begin
                            ev <= ev + EV_W'(1);
                        end else if (clu != CLU_W'(CLUSTERS - 1)) begin
                            clu   <= clu + CLU_W'(1);
                            state <= ST_STAMP;
                        end else begin
                            clu   <= '0;
                            chunk <= chunk + CH_W'(1);
                            state <= (chunk + CH_W'(1) == n_chunks) ? ST_DONE : ST_STAMP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tcd_chk.sv
// Protocol checks for the capture cluster decoder, bound to its ports.
module tcd_chk #(
    parameter int SMP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_valid,
    input logic             word_ready,
    input logic [SMP_W-1:0] smp_out,
    input logic             smp_trig,
    input logic             smp_valid,
    input logic             smp_ready,
    input logic             finished
);
    // R10
    held_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !smp_ready |=> smp_valid && $stable(smp_out) && $stable(smp_trig));
    // R9
    trig_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_trig |-> smp_valid);
    // R7
    finished_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> !smp_valid && !word_ready);
    // R7
    finished_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> finished);
    // R11
    event_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_ready && smp_valid |-> smp_ready);
endmodule

bind ts_cluster_decoder tcd_chk #(.SMP_W(SMP_W)) u_tcd_chk (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .smp_out(smp_out), .smp_trig(smp_trig), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .finished(finished)
);

// File: tb/ts_cluster_decoder_test.sv
`timescale 1ns/1ps
module ts_cluster_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = '0;
    logic [23:0] stop_pos = '0, trig_pos = '0;
    logic        trig_en = 1'b0;
    logic [15:0] word_in = '0;
    logic        word_valid = 1'b0, smp_ready = 1'b0;
    logic        word_ready, smp_trig, smp_valid, finished;
    logic [15:0] smp_out;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    ts_cluster_decoder uut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .stop_pos(stop_pos),
        .trig_en(trig_en), .trig_pos(trig_pos), .word_in(word_in),
        .word_valid(word_valid), .word_ready(word_ready), .smp_out(smp_out),
        .smp_trig(smp_trig), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .finished(finished)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [23:0] stop;
        logic        ten;
        logic [23:0] tpos;
        logic        bp;
    } case_t;

    localparam int NCASE = 6;
    localparam case_t CASES [NCASE] = '{
        '{2'd0, 24'd552,  1'b0, 24'd0,   1'b0},   // two chunks, final partial
        '{2'd1, 24'd100,  1'b1, 24'd30,  1'b1},   // final chunk is first chunk
        '{2'd2, 24'd700,  1'b1, 24'd572, 1'b1},   // trigger in chunk 1
        '{2'd1, 24'd1024, 1'b1, 24'd600, 1'b0},   // zero offset final chunk, trigger never reached
        '{2'd3, 24'd300,  1'b0, 24'd0,   1'b1},   // code 3 acts as four samples
        '{2'd0, 24'd0,    1'b0, 24'd0,   1'b0}    // empty capture
    };

    logic [15:0] words [0:2047];
    logic [15:0] exp_s [0:8191];
    int nwords, exp_n, exp_tr;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] unpack_ref(input logic [15:0] ev, input int spe, input int k);
        logic [15:0] s = '0;
        for (int l = 0; l < 16 / spe; l++) s[l] = ev[l*spe + k];
        return s;
    endfunction

    // build input words and the expected stream straight from the requirements
    task automatic build(input case_t c);
        int spe, nch, ts, prev, effp, lim, diff, pad;
        bit first, stopped;
        logic [15:0] last, ev;
        spe = (c.sel == 2'd0) ? 1 : (c.sel == 2'd1) ? 2 : 4;
        nch = (int'(c.stop) + 511) / 512;
        nwords = nch * 512;
        ts = 100;
        for (int ch = 0; ch < nch; ch++)
            for (int cl = 0; cl < 64; cl++) begin
                if (ch != 0 || cl != 0)
                    ts += (((cl*5 + ch*3) % 4) == 0) ? 8 + (cl % 4) : 7;
                words[(ch*64 + cl)*8] = 16'(ts);
                for (int e = 0; e < 7; e++)
                    words[(ch*64 + cl)*8 + 1 + e] =
                        16'(cl*16'h9E37 + e*16'h03B1 + ch*16'h07F1) ^ 16'hA5A5;
            end
        exp_n = 0; exp_tr = -1; first = 1; prev = 0; last = '0; lim = 0; stopped = 0;
        for (int ch = 0; ch < nch; ch++)
            for (int cl = 0; cl < 64; cl++) begin
                if (!stopped) begin
                    ts = int'(words[(ch*64 + cl)*8]);
                    effp = first ? ts - 1 : prev;
                    if (ch == nch - 1 && cl == 0) lim = int'(c.stop % 512) + effp;   // R8
                    if (ch == nch - 1 && ts > lim) stopped = 1;
                    else begin
                        diff = first ? 1 : ((ts - prev) & 16'hFFFF);             // R6
                        pad = diff*spe - 7*spe;                                  // R4
                        for (int p = 0; p < pad; p++) begin exp_s[exp_n] = last; exp_n++; end
                        if (c.ten && ch == int'(c.tpos / 512) && cl == int'(c.tpos % 512) / 7)
                            exp_tr = exp_n;                                      // R9
                        for (int e = 0; e < 7; e++) begin
                            ev = words[(ch*64 + cl)*8 + 1 + e];
                            for (int k = 0; k < spe; k++) begin
                                last = unpack_ref(ev, spe, k);                   // R3
                                exp_s[exp_n] = last; exp_n++;
                            end
                        end
                        prev = ts; first = 0;
                    end
                end
            end
    endtask

    task automatic run_case(input int ci);
        case_t c = CASES[ci];
        int widx = 0, outn = 0, trig_seen = 0, cyc = 0;
        bit was_held = 0;
        logic [15:0] held = '0;
        build(c);
        @(negedge clk);
        rst_n = 1'b0; word_valid = 1'b0; smp_ready = 1'b0;
        rate_sel = c.sel; stop_pos = c.stop; trig_en = c.ten; trig_pos = c.tpos;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(smp_valid == 1'b0, "R1", "smp_valid after reset", smp_valid, 0);
        chk(finished == (c.stop == 0), "R1", "finished after reset", finished, c.stop == 0);
        chk(word_ready == (c.stop != 0), "R1", "word_ready after reset", word_ready, c.stop != 0);
        while (!finished && cyc < 30000) begin
            @(negedge clk);
            cyc++;
            word_valid = (widx < nwords);
            word_in    = words[widx < nwords ? widx : 0];
            smp_ready  = c.bp ? ((cyc % 3) != 0) : 1'b1;
            #1;
            if (was_held)   // R10 held sample stays put
                chk(smp_valid && smp_out == held, "R10", "held sample", smp_out, held);
            was_held = smp_valid && !smp_ready;
            held = smp_out;
            if (smp_valid && smp_ready) begin
                if (outn < exp_n)   // R3 R4 R5 sample stream
                    chk(smp_out == exp_s[outn], "R3/R4/R5", $sformatf("sample %0d", outn),
                        smp_out, exp_s[outn]);
                else
                    chk(1'b0, "R8", "extra sample", outn, exp_n);
                chk(smp_trig == (outn == exp_tr), "R9", $sformatf("marker at %0d", outn),
                    smp_trig, outn == exp_tr);
                if (smp_trig) trig_seen++;
                outn++;
            end
            if (word_valid && word_ready) widx++;
        end
        // R7 R8 end of run
        chk(finished == 1'b1, "R7", "finished reached", finished, 1);
        chk(outn == exp_n, "R8", "sample count", outn, exp_n);
        chk(trig_seen == (exp_tr >= 0 ? 1 : 0), "R9", "marker count", trig_seen, exp_tr >= 0);
        @(negedge clk);
        #1;
        chk(!smp_valid && !word_ready && finished, "R7", "quiet after finish",
            {smp_valid, word_ready, finished}, 1);
    endtask

    // directed: timestamp alone yields no sample; event held until last sub-sample
    task automatic directed_stamp();
        @(negedge clk);
        rst_n = 1'b0; rate_sel = 2'd2; stop_pos = 24'd600; trig_en = 1'b0;
        smp_ready = 1'b0; word_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        word_valid = 1'b1; word_in = 16'd50; smp_ready = 1'b1;
        #1;
        // R2 timestamp word takes no output slot
        chk(word_ready && !smp_valid, "R2", "stamp consumed silently", {word_ready, smp_valid}, 2);
        @(negedge clk);
        word_in = 16'hF00F;
        #1;
        // R11 first event word waits for its fourth sample; R6 no fill on first cluster
        chk(smp_valid && !word_ready, "R11", "event not taken early", {smp_valid, word_ready}, 2);
        chk(smp_out == 16'h0009, "R6", "first sample no fill", smp_out, 16'h0009);
        for (int k = 1; k < 4; k++) @(negedge clk);
        #1;
        chk(word_ready && smp_out == 16'h0009, "R11", "event taken on last sub-sample",
            {word_ready, smp_out}, {1'b1, 16'h0009});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < NCASE; i++) run_case(i);
        directed_stamp();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule